// File: doc/BRIEF.md
# Read-Wide Dual-Port Matrix Buffer

This block is an on-chip buffer that holds operand matrices for a matrix-multiply engine. Its two ports work on their own clocks. The write port takes 32-bit words from the bus side. The read port gives 128-bit words to the compute side. Four consecutive narrow addresses make up one wide word, so a bus-side loader can fill a row one narrow word at a time. The compute array then fetches the whole row in a single read.

The storage is plain inferable memory of 4096 wide rows, 64 KB in total. The write port uses a 14-bit narrow address and per-byte write enables. The read port uses a 12-bit row address and returns registered data one clock after the address. Each port has an enable that gates every access, and a reset that applies to that port only.

Top module: `asym_read_wide_buf`

## Requirements
- R1: A narrow write to address a goes to wide row a[13:2], in lane a[1:0]. Lane k occupies bits 32k+31:32k of the wide word, so lane 0 is bits 31:0.
- R2: With rdEn high at a rising rdClk edge, rdData shows the row at rdAddr after that edge and not before it. The latency is one cycle.
- R3: While rdEn is low, rdData keeps its previous value, whatever rdAddr does.
- R4: While wrEn is low, the stored contents do not change.
- R5: Bit j of wrByteEn enables bits 8j+7:8j of wrData. A byte whose enable is cleared keeps its stored value.
- R6: If a row is written and read at the same clock edge, the read returns the data the row held before the write.
- R7: While rdRstN is low, rdData is zero. The reset acts asynchronously.
- R8: While wrRstN is low, no write takes effect, even with wrEn high.
- R9: The extreme addresses map correctly: narrow address 0 goes to row 0 lane 0, and narrow address 16383 goes to row 4095 lane 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write port clock |
| wrRstN | input | 1 | Write port reset, active low; blocks writes |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 14 | Narrow word address |
| wrData | input | 32 | Narrow write data |
| wrByteEn | input | 4 | Byte enables for wrData |
| rdClk | input | 1 | Read port clock |
| rdRstN | input | 1 | Read port reset, active low; clears rdData |
| rdEn | input | 1 | Read enable |
| rdAddr | input | 12 | Wide row address |
| rdData | output | 128 | Registered wide read data |

## Verification
The assertions assume the write inputs, including wrByteEn, are known whenever wrEn is sampled high. They also assume each port's reset starts low at time zero, so the read register starts from a defined zero. The stimulus changes every input only on falling clock edges. Both ports share one clock in the bench, which puts the same-row write and read of the collision test on one rising edge. Rows are read back only after all four lanes have been written, so every compared bit is defined.

// File: rtl/asym_buf_pkg.sv
package asym_buf_pkg;

  // Per-cycle strobes from the control to the datapath
  typedef struct packed {
    logic wrFire;   // a write is allowed this wrClk cycle
    logic rdFire;   // a read is allowed this rdClk cycle
  } portStrobe_t;

endpackage

// File: rtl/asym_buf_ctrl.sv
module asym_buf_ctrl
  import asym_buf_pkg::*;
(
  input  logic        wrRstN,
  input  logic        wrEn,
  input  logic        rdRstN,
  input  logic        rdEn,
  output portStrobe_t strobe
);

  // Each port's enable is qualified only by that port's own reset
  always_comb begin
    strobe.wrFire = wrEn & wrRstN;
    strobe.rdFire = rdEn & rdRstN;
  end

endmodule

// File: rtl/asym_buf_lane_map.sv
module asym_buf_lane_map #(
  parameter int NARROW_W  = 32,
  parameter int RATIO     = 4,
  parameter int WR_ADDR_W = 14,
  localparam int LANE_W       = $clog2(RATIO),
  localparam int ROW_W        = WR_ADDR_W - LANE_W,
  localparam int NARROW_BYTES = NARROW_W / 8,
  localparam int WIDE_BYTES   = NARROW_BYTES * RATIO,
  localparam int WIDE_W       = NARROW_W * RATIO
) (
  input  logic                    wrFire,
  input  logic [WR_ADDR_W-1:0]    wrAddr,
  input  logic [NARROW_W-1:0]     wrData,
  input  logic [NARROW_BYTES-1:0] wrByteEn,
  output logic [ROW_W-1:0]        wrRow,
  output logic [WIDE_BYTES-1:0]   wideByteWe,
  output logic [WIDE_W-1:0]       wideWrData
);

  logic [LANE_W-1:0] laneSel;

  // The upper address bits pick the row, the low bits pick the lane
  assign wrRow   = wrAddr[WR_ADDR_W-1:LANE_W];
  assign laneSel = wrAddr[LANE_W-1:0];

  // Every lane sees the same narrow word; only the selected lane gets enables
  generate
    for (genvar lane = 0; lane < RATIO; lane++) begin : gLane
      assign wideWrData[lane*NARROW_W +: NARROW_W] = wrData;
      assign wideByteWe[lane*NARROW_BYTES +: NARROW_BYTES] =
        (wrFire && (laneSel == LANE_W'(lane))) ? wrByteEn : '0;
    end
  endgenerate

endmodule

// File: rtl/asym_buf_datapath.sv
module asym_buf_datapath
  import asym_buf_pkg::*;
#(
  parameter int WIDE_W     = 128,
  parameter int WIDE_DEPTH = 4096,
  localparam int ROW_W      = $clog2(WIDE_DEPTH),
  localparam int WIDE_BYTES = WIDE_W / 8
) (
  input  logic                  wrClk,
  input  logic                  rdClk,
  input  logic                  rdRstN,
  input  portStrobe_t           strobe,
  input  logic [ROW_W-1:0]      wrRow,
  input  logic [WIDE_BYTES-1:0] wideByteWe,
  input  logic [WIDE_W-1:0]     wideWrData,
  input  logic [ROW_W-1:0]      rdRow,
  output logic [WIDE_W-1:0]     rdWord
);

  logic [WIDE_W-1:0] memArray [WIDE_DEPTH];

  // Byte-column write; lanes that are not selected have all enables low
  always_ff @(posedge wrClk) begin
    if (strobe.wrFire) begin
      for (int b = 0; b < WIDE_BYTES; b++) begin
        if (wideByteWe[b]) memArray[wrRow][b*8 +: 8] <= wideWrData[b*8 +: 8];
      end
    end
  end

  // Registered read; a write at the same edge is not yet visible (read-first)
  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)            rdWord <= '0;
    else if (strobe.rdFire) rdWord <= memArray[rdRow];
  end

endmodule

// File: rtl/asym_read_wide_buf.sv
module asym_read_wide_buf
  import asym_buf_pkg::*;
#(
  parameter int NARROW_W   = 32,
  parameter int RATIO      = 4,
  parameter int WIDE_DEPTH = 4096,
  localparam int WIDE_W       = NARROW_W * RATIO,
  localparam int RD_ADDR_W    = $clog2(WIDE_DEPTH),
  localparam int WR_ADDR_W    = RD_ADDR_W + $clog2(RATIO),
  localparam int NARROW_BYTES = NARROW_W / 8,
  localparam int WIDE_BYTES   = WIDE_W / 8
) (
  input  logic                    wrClk,
  input  logic                    wrRstN,
  input  logic                    wrEn,
  input  logic [WR_ADDR_W-1:0]    wrAddr,
  input  logic [NARROW_W-1:0]     wrData,
  input  logic [NARROW_BYTES-1:0] wrByteEn,
  input  logic                    rdClk,
  input  logic                    rdRstN,
  input  logic                    rdEn,
  input  logic [RD_ADDR_W-1:0]    rdAddr,
  output logic [WIDE_W-1:0]       rdData
);

  portStrobe_t            strobe;
  logic [RD_ADDR_W-1:0]   wrRow;
  logic [WIDE_BYTES-1:0]  wideByteWe;
  logic [WIDE_W-1:0]      wideWrData;

  asym_buf_ctrl ctrl_i (
    .wrRstN (wrRstN),
    .wrEn   (wrEn),
    .rdRstN (rdRstN),
    .rdEn   (rdEn),
    .strobe (strobe)
  );

  asym_buf_lane_map #(
    .NARROW_W  (NARROW_W),
    .RATIO     (RATIO),
    .WR_ADDR_W (WR_ADDR_W)
  ) laneMap_i (
    .wrFire     (strobe.wrFire),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .wrByteEn   (wrByteEn),
    .wrRow      (wrRow),
    .wideByteWe (wideByteWe),
    .wideWrData (wideWrData)
  );

  asym_buf_datapath #(
    .WIDE_W     (WIDE_W),
    .WIDE_DEPTH (WIDE_DEPTH)
  ) datapath_i (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .rdRstN     (rdRstN),
    .strobe     (strobe),
    .wrRow      (wrRow),
    .wideByteWe (wideByteWe),
    .wideWrData (wideWrData),
    .rdRow      (rdAddr),
    .rdWord     (rdData)
  );

endmodule

// File: rtl/asym_buf_checker.sv
module asym_buf_checker #(
  parameter int NARROW_BYTES = 4,
  parameter int RATIO        = 4,
  parameter int WIDE_W       = 128,
  localparam int WIDE_BYTES  = NARROW_BYTES * RATIO
) (
  input logic                    wrClk,
  input logic                    wrRstN,
  input logic                    wrEn,
  input logic [NARROW_BYTES-1:0] wrByteEn,
  input logic [WIDE_BYTES-1:0]   wideByteWe,
  input logic                    rdClk,
  input logic                    rdRstN,
  input logic                    rdEn,
  input logic [WIDE_W-1:0]       rdData
);

  logic [RATIO-1:0] laneHit;

  always_comb begin
    for (int l = 0; l < RATIO; l++) laneHit[l] = |wideByteWe[l*NARROW_BYTES +: NARROW_BYTES];
  end

  AST_RD_HOLD: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !rdEn |=> $stable(rdData)); // R3

  AST_RD_RESET_ZERO: assert property (@(posedge rdClk)
    !rdRstN |=> (rdData == '0)); // R7

  AST_WR_IDLE: assert property (@(posedge wrClk)
    (!wrEn || !wrRstN) |-> (wideByteWe == '0)); // R4 R8

  AST_ONE_LANE: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrEn |-> $onehot0(laneHit)); // R1

  AST_BYTE_COUNT: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrEn |-> ($countones(wideByteWe) == $countones(wrByteEn))); // R5

endmodule

bind asym_read_wide_buf asym_buf_checker #(
  .NARROW_BYTES (NARROW_BYTES),
  .RATIO        (RATIO),
  .WIDE_W       (WIDE_W)
) chk_i (
  .wrClk      (wrClk),
  .wrRstN     (wrRstN),
  .wrEn       (wrEn),
  .wrByteEn   (wrByteEn),
  .wideByteWe (wideByteWe),
  .rdClk      (rdClk),
  .rdRstN     (rdRstN),
  .rdEn       (rdEn),
  .rdData     (rdData)
);

// File: tb/asym_read_wide_buf_tb_top.sv
`timescale 1ns/1ps
module asym_read_wide_buf_tb_top;

  typedef struct packed {
    logic [13:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
  } wrVec_t;

  localparam int NVEC = 13;
  localparam wrVec_t VECS [NVEC] = '{
    '{14'd0,     32'h11111111, 4'hF},
    '{14'd1,     32'h22222222, 4'hF},
    '{14'd2,     32'h33333333, 4'hF},
    '{14'd3,     32'h44444444, 4'hF},
    '{14'd7,     32'hA5A5A5A5, 4'hF},
    '{14'd4,     32'h01234567, 4'hF},
    '{14'd5,     32'h89ABCDEF, 4'hF},
    '{14'd6,     32'hDEADBEEF, 4'hF},
    '{14'd16383, 32'hCAFEF00D, 4'hF},
    '{14'd16380, 32'h00000000, 4'hF},
    '{14'd16381, 32'h00000000, 4'hF},
    '{14'd16382, 32'h00000000, 4'hF},
    '{14'd5,     32'h00FF00FF, 4'b0101}
  };

  logic        clk = 1'b0;
  logic        wrRstN, wrEn, rdRstN, rdEn;
  logic [13:0] wrAddr;
  logic [31:0] wrData;
  logic [3:0]  wrByteEn;
  logic [11:0] rdAddr;
  logic [127:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [127:0] model [int];

  always #5 clk = ~clk;

  asym_read_wide_buf dut_i (
    .wrClk(clk), .wrRstN(wrRstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wrByteEn(wrByteEn),
    .rdClk(clk), .rdRstN(rdRstN), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected contents follow R1 and R5: row = a>>2, lane = a[1:0], byte j gated by be[j]
  task automatic modelWrite(input logic [13:0] a, input logic [31:0] d, input logic [3:0] be);
    int row = int'(a >> 2);
    int lane = int'(a[1:0]);
    logic [127:0] w = model.exists(row) ? model[row] : '0;
    for (int j = 0; j < 4; j++) if (be[j]) w[lane*32 + j*8 +: 8] = d[j*8 +: 8];
    model[row] = w;
  endtask

  task automatic doWrite(input logic [13:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrByteEn = be;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [11:0] r, output logic [127:0] q);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = r;
    @(negedge clk);
    rdEn = 1'b0;
    q = rdData;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [127:0] q, prev;
    wrRstN = 1'b0; rdRstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    wrAddr = '0; wrData = '0; wrByteEn = '0; rdAddr = '0;
    repeat (3) @(negedge clk);
    check("R7 reset value", rdData, '0);
    wrRstN = 1'b1; rdRstN = 1'b1;

    // Vector walk: R1 lane placement, R5 partial bytes, R9 extreme addresses
    for (int i = 0; i < NVEC; i++) begin
      doWrite(VECS[i].addr, VECS[i].data, VECS[i].be);
      modelWrite(VECS[i].addr, VECS[i].data, VECS[i].be);
    end
    doRead(12'd0, q);
    for (int l = 0; l < 4; l++) check("R1 row0 lane", 128'(q[l*32 +: 32]), 128'(model[0][l*32 +: 32]));
    doRead(12'd1, q);
    for (int l = 0; l < 4; l++) check("R5 row1 lane", 128'(q[l*32 +: 32]), 128'(model[1][l*32 +: 32]));
    doRead(12'd4095, q);
    for (int l = 0; l < 4; l++) check("R9 row4095 lane", 128'(q[l*32 +: 32]), 128'(model[4095][l*32 +: 32]));

    // R2: one-cycle latency
    doRead(12'd1, prev);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 12'd0;
    #1 check("R2 before edge", rdData, prev);
    @(negedge clk);
    rdEn = 1'b0;
    check("R2 after edge", rdData, model[0]);

    // R3: hold while read disabled
    rdAddr = 12'd1;
    repeat (2) @(negedge clk);
    check("R3 hold", rdData, model[0]);

    // R4: disabled write leaves contents
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 14'd1; wrData = 32'hFFFFFFFF; wrByteEn = 4'hF;
    @(negedge clk);
    doRead(12'd0, q);
    check("R4 no write", q, model[0]);

    // R8: write port reset blocks writes
    wrRstN = 1'b0;
    doWrite(14'd2, 32'h0BAD0BAD, 4'hF);
    wrRstN = 1'b1;
    doRead(12'd0, q);
    check("R8 no write in reset", q, model[0]);

    // R6: same-edge write and read of row 0 returns the old row
    prev = model[0];
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 14'd0; wrData = 32'h77777777; wrByteEn = 4'hF;
    rdEn = 1'b1; rdAddr = 12'd0;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    modelWrite(14'd0, 32'h77777777, 4'hF);
    check("R6 old data", rdData, prev);
    doRead(12'd0, q);
    check("R6 new data", q, model[0]);

    // R7: asynchronous clear mid-run
    @(negedge clk);
    rdRstN = 1'b0;
    #1 check("R7 async clear", rdData, '0);
    @(negedge clk);
    rdRstN = 1'b1;

    finishRun();
  end

endmodule